// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is the target side of a serial command link. A host selects the block by pulling chip select low, clocks in one 16-bit word on SCK, most significant bit first, then releases chip select. The block samples SCK, chip select and MOSI into its own system clock domain through two-flop synchronizers. It finds the clock and select edges there and shifts the word in. When chip select is released it acts on the frame.

The top four bits of a word are a command code and the lower twelve bits are a payload. Command 4'h1 loads the payload into a 12-bit mode register, where zero means "off". Command 4'h2 sets or clears a trace flag from payload bit 0. Each write is marked by a one-cycle strobe. Any other code is dropped. A frame that did not carry exactly 16 rising SCK edges is also dropped. The system clock must run at least four times as fast as SCK.

Top module: `spi_cmd_rx`

## Requirements
- R1: After synchronous reset, mode_q is 0, trace_en is 0, and both write strobes are low.
- R2: Bits are captured on rising SCK edges while cs_n is low, most significant bit first; word bits [15:12] form the command and bits [11:0] form the payload.
- R3: A valid frame with command 4'h1 loads the payload into mode_q, and mode_wr goes high for exactly one cycle. mode_q changes in no other cycle.
- R4: A valid frame with command 4'h2 sets trace_en to payload bit 0, and trace_wr goes high for one cycle; payload bits [11:1] have no effect.
- R5: A frame with any command other than 4'h1 or 4'h2 changes neither register and raises no strobe.
- R6: A frame is discarded when the number of rising SCK edges between the cs_n fall and the cs_n rise is not exactly 16. Such a frame writes no register and raises no strobe.
- R7: SCK edges and MOSI activity while cs_n is high are ignored, and they do not disturb the next frame.
- R8: At most one strobe fires per frame, mode_wr and trace_wr are never high together, and each strobe lasts one cycle.
- R9: A frame is acted on only at the release of cs_n, and its register write appears within 6 system clock cycles of that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Chip select, active low, one word per assertion |
| mosi | input | 1 | Serial data from host |
| mode_q | output | 12 | Mode configuration register |
| mode_wr | output | 1 | One-cycle pulse when mode_q is written |
| trace_en | output | 1 | Trace enable flag |
| trace_wr | output | 1 | One-cycle pulse when trace_en is written |

## Verification
The assertions check several rules on every cycle. Both registers hold their value in every cycle without a strobe, the two strobes never overlap, every strobe follows a completed frame, and a frame completes only while the synchronized select is released. Some behaviour shows only at the ports across a whole transfer, so the bench's scenarios must cover it. This includes the most-significant-bit-first bit order and the split into command and payload. It also includes the decode of all sixteen command codes, the rejection of short and long frames, and the immunity to SCK activity while the block is not selected.

// File: rtl/spi_cmd_rx_pkg.sv
package spi_cmd_rx_pkg;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_MODE  = 2'd1,
    DEC_TRACE = 2'd2
  } dec_kind_e;

endpackage

// File: rtl/spi_cmd_rx_sync.sv
module spi_cmd_rx_sync #(
  parameter int             WIDTH    = 3,
  parameter int             STAGES   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/spi_cmd_rx_shifter.sv
module spi_cmd_rx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  output logic              frame_vld,
  output logic [WORD_W-1:0] frame_word
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic              sclk_d;
  logic              cs_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  logic sclk_rise, cs_fall, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_fall   = ~cs_n_s & cs_d;
  assign cs_rise   = cs_n_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (!cs_n_s && sclk_rise) begin
      shreg <= {shreg[WORD_W-2:0], mosi_s};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_vld <= 1'b0;
      if (cs_rise && bit_cnt == CNT_FULL) begin
        frame_vld  <= 1'b1;
        frame_word <= shreg;
      end
    end
  end

  // A completed frame is only reported once the select is seen released.
  assert_frame_on_release_R9: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> cs_n_s);

  // The bit counter never moves while the block is deselected.
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && cs_d) |=> $stable(bit_cnt));

endmodule

// File: rtl/spi_cmd_rx_decode.sv
module spi_cmd_rx_decode
  import spi_cmd_rx_pkg::*;
#(
  parameter int CMD_W      = 4,
  parameter int DATA_W     = 12,
  parameter int CMD_SETCFG = 1,
  parameter int CMD_TRACE  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_vld,
  input  logic [CMD_W+DATA_W-1:0] frame_word,
  output logic [DATA_W-1:0]       mode_q,
  output logic                    mode_wr,
  output logic                    trace_en,
  output logic                    trace_wr
);

  localparam logic [CMD_W-1:0] OP_SETCFG = CMD_W'(CMD_SETCFG);
  localparam logic [CMD_W-1:0] OP_TRACE  = CMD_W'(CMD_TRACE);

  logic [CMD_W-1:0]  cmd_f;
  logic [DATA_W-1:0] data_f;
  dec_kind_e         kind;

  assign cmd_f  = frame_word[CMD_W+DATA_W-1:DATA_W];
  assign data_f = frame_word[DATA_W-1:0];

  always_comb begin
    if (cmd_f == OP_SETCFG)     kind = DEC_MODE;
    else if (cmd_f == OP_TRACE) kind = DEC_TRACE;
    else                        kind = DEC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      trace_en <= 1'b0;
      mode_wr  <= 1'b0;
      trace_wr <= 1'b0;
    end else begin
      mode_wr  <= 1'b0;
      trace_wr <= 1'b0;
      if (frame_vld) begin
        case (kind)
          DEC_MODE: begin
            mode_q  <= data_f;
            mode_wr <= 1'b1;
          end
          DEC_TRACE: begin
            trace_en <= data_f[0];
            trace_wr <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(mode_wr && trace_wr));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |-> $stable(mode_q));

  assert_trace_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !trace_wr |-> $stable(trace_en));

  assert_wr_needs_frame_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_wr || trace_wr) |-> $past(frame_vld));

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int WORD_W      = 16,
  parameter int CMD_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CMD_SETCFG  = 1,
  parameter int CMD_TRACE   = 2,
  localparam int DATA_W     = WORD_W - CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic [DATA_W-1:0] mode_q,
  output logic              mode_wr,
  output logic              trace_en,
  output logic              trace_wr
);

  // Bit order in the synchronized bundle: [2]=select, [1]=clock, [0]=data.
  logic [2:0]        pins_s;
  logic              frame_vld;
  logic [WORD_W-1:0] frame_word;

  spi_cmd_rx_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async({cs_n, sclk, mosi}),
    .q_sync (pins_s)
  );

  spi_cmd_rx_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s[1]),
    .cs_n_s    (pins_s[2]),
    .mosi_s    (pins_s[0]),
    .frame_vld (frame_vld),
    .frame_word(frame_word)
  );

  spi_cmd_rx_decode #(
    .CMD_W     (CMD_W),
    .DATA_W    (DATA_W),
    .CMD_SETCFG(CMD_SETCFG),
    .CMD_TRACE (CMD_TRACE)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .frame_word(frame_word),
    .mode_q    (mode_q),
    .mode_wr   (mode_wr),
    .trace_en  (trace_en),
    .trace_wr  (trace_wr)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (mode_q == '0 && !trace_en && !mode_wr && !trace_wr));

endmodule

// File: tb/spi_cmd_rx_tb.sv
module spi_cmd_rx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic [11:0] mode_q;
  logic        mode_wr, trace_en, trace_wr;

  int n_chk = 0;
  int n_bad = 0;
  int mode_pulses = 0;
  int trace_pulses = 0;
  int overlap_cnt = 0;
  int long_pulse_cnt = 0;
  logic prev_mwr = 1'b0, prev_twr = 1'b0;

  logic [11:0] exp_mode;
  logic        exp_trace;
  int          exp_mp, exp_tp;

  always #4 clk = ~clk;

  spi_cmd_rx u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .mode_q(mode_q), .mode_wr(mode_wr), .trace_en(trace_en), .trace_wr(trace_wr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (mode_wr)  mode_pulses++;
      if (trace_wr) trace_pulses++;
      if (mode_wr && trace_wr) overlap_cnt++;
      if ((mode_wr && prev_mwr) || (trace_wr && prev_twr)) long_pulse_cnt++;
    end
    prev_mwr = mode_wr;
    prev_twr = trace_wr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] bits, input int nbits);
    cs_n = 1'b0;
    wclk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = bits[i];
      wclk(4);
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
    end
    wclk(4);
    cs_n = 1'b1;
    wclk(8);
  endtask

  task automatic check_state(input string req);
    chk({req, " mode_q"}, 32'(mode_q), 32'(exp_mode));
    chk({req, " trace_en"}, 32'(trace_en), 32'(exp_trace));
    chk({req, " mode strobes"}, 32'(mode_pulses), 32'(exp_mp));
    chk({req, " trace strobes"}, 32'(trace_pulses), 32'(exp_tp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] d;
    wclk(5);
    rst = 1'b0;
    wclk(2);
    exp_mode = '0; exp_trace = 1'b0; exp_mp = 0; exp_tp = 0;
    // R1: reset values
    chk("R1 mode_q", 32'(mode_q), 0);
    chk("R1 trace_en", 32'(trace_en), 0);
    chk("R1 strobes", 32'({mode_wr, trace_wr}), 0);

    // R3/R5: sweep every command code; only 1 and 2 act (R4 for code 2)
    for (int c = 0; c < 16; c++) begin
      d = 12'((c * 12'h2B7) ^ 12'hA5C);
      send({16'h0, 4'(c), d}, 16);
      if (c == 1) begin exp_mode = d; exp_mp++; end
      if (c == 2) begin exp_trace = d[0]; exp_tp++; end
      check_state(c == 1 ? "R3" : (c == 2 ? "R4" : "R5"));
    end

    // R2/R3: payload sweep, walking ones and arithmetic values check bit order
    for (int k = 0; k < 40; k++) begin
      d = (k < 12) ? (12'h1 << k) : 12'((k * 65) + 7);
      send({16'h0, 4'h1, d}, 16);
      exp_mode = d; exp_mp++;
      check_state("R2");
    end
    send({16'h0, 4'h1, 12'hFFF}, 16); exp_mode = 12'hFFF; exp_mp++; check_state("R3");
    send({16'h0, 4'h1, 12'h000}, 16); exp_mode = 12'h000; exp_mp++; check_state("R3");

    // R4: trace uses bit 0 only
    begin
      logic [11:0] tv [4] = '{12'h001, 12'hFFE, 12'h003, 12'h800};
      for (int t = 0; t < 4; t++) begin
        send({16'h0, 4'h2, tv[t]}, 16);
        exp_trace = tv[t][0]; exp_tp++;
        check_state("R4");
      end
    end

    // R6: wrong frame lengths are dropped
    send({16'h0, 4'h1, 12'h5A5}, 16); exp_mode = 12'h5A5; exp_mp++;
    begin
      int lens [6] = '{1, 8, 15, 17, 20, 0};
      for (int j = 0; j < 6; j++) begin
        send({11'h0, 4'h1, 12'h3C3, 5'h1F} >> (21 - lens[j]), lens[j]);
        check_state("R6");
      end
    end

    // R7: clock activity while deselected is ignored, next frame intact
    for (int i = 0; i < 20; i++) begin
      mosi = i[0];
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(8);
    check_state("R7");
    send({16'h0, 4'h1, 12'h9E1}, 16); exp_mode = 12'h9E1; exp_mp++;
    check_state("R7");

    // R9: write lands within 6 cycles of select release
    cs_n = 1'b0; wclk(4);
    for (int i = 15; i >= 0; i--) begin
      mosi = (16'h1234 >> i) & 1;
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(4);
    cs_n = 1'b1;
    wclk(1);
    chk("R9 not before release", 32'(mode_q), 32'h9E1);
    wclk(5);
    chk("R9 written after release", 32'(mode_q), 32'h234);
    exp_mode = 12'h234; exp_mp++;
    wclk(4);
    check_state("R9");

    // R8: strobe shape across whole run
    chk("R8 overlap", 32'(overlap_cnt), 0);
    chk("R8 pulse width", 32'(long_pulse_cnt), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule